// File: doc/BRIEF.md
# Segmented Resistor-String DAC Control Logic

This block holds the digital control for one channel of a three-segment digital-to-analog converter. A signed two's-complement sample arrives on a one-cycle strobe. The block converts it to offset binary by inverting its sign bit. It then divides the code among three conversion mechanisms:

- The upper field is a static tap index into a resistor string. The string offers two neighbouring potentials one unit step apart.
- The middle field sets a time-domain duty ratio. A select line toggles between the upper and the lower of those two potentials.
- The lower field sets a pair of trim resistor codes. These codes slide both potentials by a fraction of a unit step, and their sum stays fixed.

Time is divided into frames of 2^PWM_W system-clock slots. A captured sample is first held in a pending register. It is applied to all three fields together at the next frame boundary, so that the analog switches never see a half-updated code. An initialization input forces the controller to the mid-scale code, which gives an output halfway between the two reference voltages. The resistors, the switches and the amplifier lie outside this block; only their control codes are produced here.

Top module: `seg_dac_ctrl`

## Requirements
- R1: The offset code is the input sample with its most significant bit inverted. `tap_idx` shows bits [17:9] of that code, so a sample of 0x20000 (most negative) gives tap 0 and a sample of 0x1FFFF gives tap 511.
- R2: Within each 8-slot frame, `sel_upper` is 1 (upper potential) for the first n slots and 0 for the remaining 8-n slots. Here n is bits [8:6] of the offset code, and slot 0 is the first slot of a frame. `sel_upper` is therefore never 1 in the last slot.
- R3: `trim_lo` equals bits [5:0] of the offset code, and `trim_hi` equals 63 minus `trim_lo`. Their sum is 63 on every cycle.
- R4: `tap_idx`, `trim_lo`, `trim_hi` and the duty ratio change only in the first slot of a frame, except when initialization forces them.
- R5: In the cycle after `init_hold` is seen high, the outputs show the mid-scale code 0x20000 (tap 256, trim_lo 0, trim_hi 63, `sel_upper` 0). A strobe accepted while `init_hold` is high has no effect, and the outputs stay at mid-scale after `init_hold` falls until a new sample is applied.
- R6: After reset, the outputs show the mid-scale code and the frame starts at slot 0 on the first clock after reset is released.
- R7: When several strobes fall inside one frame, only the last one captured before the boundary takes effect at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one PWM slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_hold | input | 1 | Synchronous initialization; forces the mid-scale code while high |
| smp_stb | input | 1 | One-cycle strobe that captures `smp_data` |
| smp_data | input | DATA_W (18) | Signed two's-complement sample |
| tap_idx | output | TAP_W (9) | Resistor-string tap index |
| sel_upper | output | 1 | 1 selects the upper neighbouring potential, 0 selects the lower |
| trim_hi | output | TRIM_W (6) | Upper level-shift resistor code |
| trim_lo | output | TRIM_W (6) | Lower level-shift resistor code |

## Verification
The checker module counts frame slots on its own and checks on every cycle that:
- the trim codes sum to full scale;
- the select pulse is one contiguous run from the start of a frame that ends before the last slot;
- tap and trim codes hold steady within a frame;
- initialization produces mid-scale outputs.

Only the bench scenarios can show the rest:
- the offset-binary mapping of each sample to its fields;
- the exact pulse length for each duty value;
- that the last of several strobes wins;
- that samples offered during initialization are discarded.

The bench sweeps all 512 tap positions, with duty and trim fields that cycle through their full ranges, and checks every slot of every frame.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
   // default split of the sample word into its three segments
   localparam int unsigned DEF_DATA_W = 18;
   localparam int unsigned DEF_TAP_W  = 9;
   localparam int unsigned DEF_PWM_W  = 3;
   localparam int unsigned DEF_TRIM_W = DEF_DATA_W - DEF_TAP_W - DEF_PWM_W;
endpackage

// File: rtl/seg_dac_split.sv
// Two's-complement to offset-binary conversion (sign inversion).
module seg_dac_split #(
   parameter int unsigned DATA_W = seg_dac_pkg::DEF_DATA_W
) (
   input  logic [DATA_W-1:0] smp_twos,
   output logic [DATA_W-1:0] smp_ofs
);
   always_comb begin
      smp_ofs             = smp_twos;
      smp_ofs[DATA_W-1]   = ~smp_twos[DATA_W-1];
   end
endmodule

// File: rtl/seg_dac_frame.sv
// Slot counter that defines the PWM frame.
module seg_dac_frame #(
   parameter int unsigned PWM_W = seg_dac_pkg::DEF_PWM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [PWM_W-1:0] slot,
   output logic             frame_last
);
   localparam logic [PWM_W-1:0] SLOT_END = {PWM_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= '0;
      else        slot <= slot + 1'b1;
   end

   assign frame_last = (slot == SLOT_END);
endmodule

// File: rtl/seg_dac_pwm.sv
// Leading-edge PWM: the upper potential for the first 'duty' slots.
module seg_dac_pwm #(
   parameter int unsigned PWM_W = seg_dac_pkg::DEF_PWM_W
) (
   input  logic [PWM_W-1:0] slot,
   input  logic [PWM_W-1:0] duty,
   output logic             sel_upper
);
   assign sel_upper = (slot < duty);
endmodule

// File: rtl/seg_dac_ctrl.sv
module seg_dac_ctrl #(
   parameter int unsigned DATA_W = seg_dac_pkg::DEF_DATA_W,
   parameter int unsigned TAP_W  = seg_dac_pkg::DEF_TAP_W,
   parameter int unsigned PWM_W  = seg_dac_pkg::DEF_PWM_W,
   parameter int unsigned TRIM_W = DATA_W - TAP_W - PWM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_hold,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   output logic [TAP_W-1:0]  tap_idx,
   output logic              sel_upper,
   output logic [TRIM_W-1:0] trim_hi,
   output logic [TRIM_W-1:0] trim_lo
);
   localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

   // elaboration-time parameter checks
   if (TAP_W + PWM_W + TRIM_W != DATA_W) begin : g_bad_split
      $error("seg_dac_ctrl: segment widths must add up to DATA_W");
   end
   if (TAP_W < 1 || PWM_W < 1 || TRIM_W < 1) begin : g_bad_width
      $error("seg_dac_ctrl: every segment needs at least one bit");
   end

   logic [DATA_W-1:0] ofs_code;
   logic [DATA_W-1:0] pend_code;
   logic [DATA_W-1:0] act_code;
   logic [PWM_W-1:0]  slot;
   logic              frame_last;

   seg_dac_split #(.DATA_W(DATA_W)) u_split (
      .smp_twos (smp_data),
      .smp_ofs  (ofs_code)
   );

   seg_dac_frame #(.PWM_W(PWM_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot       (slot),
      .frame_last (frame_last)
   );

   // pending sample and frame-aligned active code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_code <= MID_CODE;
         act_code  <= MID_CODE;
      end else if (init_hold) begin
         pend_code <= MID_CODE;
         act_code  <= MID_CODE;
      end else begin
         if (smp_stb)    pend_code <= ofs_code;
         if (frame_last) act_code  <= pend_code;
      end
   end

   assign tap_idx = act_code[DATA_W-1 -: TAP_W];
   assign trim_lo = act_code[TRIM_W-1:0];

   seg_dac_pwm #(.PWM_W(PWM_W)) u_pwm (
      .slot      (slot),
      .duty      (act_code[TRIM_W +: PWM_W]),
      .sel_upper (sel_upper)
   );

   // complementary trim: (2^TRIM_W - 1) - x is the bitwise inverse of x
   for (genvar b = 0; b < TRIM_W; b++) begin : g_trim
      assign trim_hi[b] = ~act_code[b];
   end
endmodule

// File: rtl/seg_dac_ctrl_chk.sv
module seg_dac_ctrl_chk #(
   parameter int unsigned DATA_W = seg_dac_pkg::DEF_DATA_W,
   parameter int unsigned TAP_W  = seg_dac_pkg::DEF_TAP_W,
   parameter int unsigned PWM_W  = seg_dac_pkg::DEF_PWM_W,
   parameter int unsigned TRIM_W = DATA_W - TAP_W - PWM_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_hold,
   input logic [TAP_W-1:0]  tap_idx,
   input logic              sel_upper,
   input logic [TRIM_W-1:0] trim_hi,
   input logic [TRIM_W-1:0] trim_lo
);
   localparam logic [TAP_W-1:0]  MID_TAP  = {1'b1, {(TAP_W-1){1'b0}}};
   localparam logic [TRIM_W:0]   TRIM_SUM = {1'b0, {TRIM_W{1'b1}}};
   localparam logic [PWM_W-1:0]  LAST     = {PWM_W{1'b1}};

   // independent frame position tracker
   logic [PWM_W-1:0] c_slot;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_slot <= '0;
      else        c_slot <= c_slot + 1'b1;
   end

   assert_trim_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, trim_hi} + {1'b0, trim_lo}) == TRIM_SUM);

   assert_sel_low_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_slot == LAST) |-> !sel_upper);

   assert_sel_single_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_upper && c_slot != '0) |-> $past(sel_upper));

   assert_hold_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_slot != '0 && !$past(init_hold)) |-> ($stable(tap_idx) && $stable(trim_lo)));

   assert_init_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_hold) |-> (tap_idx == MID_TAP && trim_lo == '0 && !sel_upper));
endmodule

bind seg_dac_ctrl seg_dac_ctrl_chk #(
   .DATA_W(DATA_W), .TAP_W(TAP_W), .PWM_W(PWM_W), .TRIM_W(TRIM_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .init_hold (init_hold),
   .tap_idx   (tap_idx),
   .sel_upper (sel_upper),
   .trim_hi   (trim_hi),
   .trim_lo   (trim_lo)
);

// File: tb/seg_dac_ctrl_test.sv
module seg_dac_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_hold = 1'b0;
   logic        smp_stb = 1'b0;
   logic [17:0] smp_data = '0;
   logic [8:0]  tap_idx;
   logic        sel_upper;
   logic [5:0]  trim_hi;
   logic [5:0]  trim_lo;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   seg_dac_ctrl uut (
      .clk(clk), .rst_n(rst_n), .init_hold(init_hold),
      .smp_stb(smp_stb), .smp_data(smp_data),
      .tap_idx(tap_idx), .sel_upper(sel_upper),
      .trim_hi(trim_hi), .trim_lo(trim_lo)
   );

   // bench's own slot count (frame starts at slot 0 after reset)
   logic [2:0] bslot;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bslot <= 3'd0;
      else        bslot <= bslot + 3'd1;
   end

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // check one full frame of outputs for a given signed sample; starts at slot 0
   task automatic check_frame(input logic [17:0] s, input string req);
      logic [17:0] code;
      int exp_tap, exp_duty, exp_lo;
      code     = s ^ 18'h20000;
      exp_tap  = int'(code >> 9);
      exp_duty = int'((code >> 6) & 18'h7);
      exp_lo   = int'(code & 18'h3F);
      for (int i = 0; i < 8; i++) begin
         chk(req, "slot", int'(bslot), i);
         chk(req, "tap_idx", int'(tap_idx), exp_tap);
         chk(req, "trim_lo", int'(trim_lo), exp_lo);
         chk(req, "trim_hi", int'(trim_hi), 63 - exp_lo);
         chk(req, "sel_upper", int'(sel_upper), (i < exp_duty) ? 1 : 0);
         @(negedge clk);
      end
   endtask

   task automatic apply(input logic [17:0] s);
      @(negedge clk);
      smp_stb = 1'b1; smp_data = s;
      @(negedge clk);
      smp_stb = 1'b0;
      do @(negedge clk); while (bslot != 3'd0);
   endtask

   initial begin
      logic [17:0] code;
      logic [17:0] s1, s2;
      int old_tap;
      // R6: state during and after reset
      repeat (3) @(negedge clk);
      chk("R6", "tap_idx in reset", int'(tap_idx), 256);
      chk("R6", "trim_lo in reset", int'(trim_lo), 0);
      chk("R6", "trim_hi in reset", int'(trim_hi), 63);
      chk("R6", "sel_upper in reset", int'(sel_upper), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6", "first slot", int'(bslot), 1);
      do @(negedge clk); while (bslot != 3'd0);
      check_frame(18'h00000, "R6");

      // R1 R2 R3: sweep every tap position with cycling duty and trim
      for (int t = 0; t < 512; t++) begin
         code = {t[8:0], t[2:0], 6'((t * 7 + 3) & 63)};
         apply(code ^ 18'h20000);
         check_frame(code ^ 18'h20000, "R1");
      end
      // R1 R3 corners: most negative, most positive, zero
      apply(18'h20000); check_frame(18'h20000, "R1");
      apply(18'h1FFFF); check_frame(18'h1FFFF, "R3");
      apply(18'h00000); check_frame(18'h00000, "R2");

      // R4 R7: two strobes inside one frame, old value held until boundary
      apply(18'h05A5A); check_frame(18'h05A5A, "R4");
      old_tap = int'((18'h05A5A ^ 18'h20000) >> 9);
      s1 = 18'h3F00F; s2 = 18'h12345;
      smp_stb = 1'b1; smp_data = s1;       // at slot 0
      @(negedge clk);
      smp_data = s2;
      @(negedge clk);
      smp_stb = 1'b0;
      while (bslot != 3'd0) begin
         chk("R4", "tap held mid-frame", int'(tap_idx), old_tap);
         @(negedge clk);
      end
      check_frame(s2, "R7");

      // R5: init forces mid-scale and discards a concurrent strobe
      @(negedge clk);   // slot 1
      init_hold = 1'b1; smp_stb = 1'b1; smp_data = 18'h1ABCD;
      @(negedge clk);
      smp_stb = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R5", "tap under init", int'(tap_idx), 256);
         chk("R5", "trim_hi under init", int'(trim_hi), 63);
         chk("R5", "sel under init", int'(sel_upper), 0);
         @(negedge clk);
      end
      init_hold = 1'b0;
      do @(negedge clk); while (bslot != 3'd0);
      check_frame(18'h00000, "R5");
      check_frame(18'h00000, "R5");
      apply(18'h2AAAA); check_frame(18'h2AAAA, "R5");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule